// File: doc/BRIEF.md
# MicroWire Serial Master Controller

This block is a synchronous serial master for a three-wire link: a serial clock, a data output and a data input. It also drives up to four chip-select pins. A host reaches it through a small register file on a 16-bit word bus, with word indices 0 to 5.

For each select, the host programs a 6-bit mode field. The field chooses:
- which clock edge samples input data,
- which clock edge changes output data,
- the active level of the select pin,
- the clock divider,
- whether the block waits for the target to report ready.

A transfer runs in up to two phases. The host loads a transmit word and writes one control word. That word names the select and gives a transmit bit count and a receive bit count. The block shifts out the upper bits of the transmit word, most significant bit first. It then clocks in the requested number of receive bits and raises a receive flag.

Asserting the select is a command of its own, separate from starting the transfer. The select therefore stays active across any number of back-to-back transfers until the host clears it.

Top module: `mw_master`

## Requirements
- R1: After reset:
  - index 1 and index 0 read 0,
  - every select pin is high (inactive, active-low by default),
  - the serial clock is low,
  - the data output is low.
- R2: A transfer with a transmit count N from 0 to 16 sends bits 15 down to 16-N of the transmit word (index 0, write), most significant first. A transfer produces exactly 2·(N+M) serial clock edges in total, where M is the receive count.
- R3: The receive phase follows the last transmit cell and takes M bits (0 to 16), first bit received most significant. The result reads back right-aligned at index 0. With M = 0 no receive phase runs and the receive flag stays clear.
- R4: Control word bit 14 (busy) reads 1 from the clock after an accepted start until the last edge. Bit 15 (receive flag) clears at an accepted start and sets when a receive phase ends.
- R5: Control word fields:
  - bits 4:0: receive count,
  - bits 9:5: transmit count,
  - bits 11:10: select number,
  - bit 12: assert the select,
  - bit 13: start.

  Mode field bits: bit 0 = sample on the rising edge, bit 1 = change output on the rising edge. A 0 in either bit means the falling edge. Output data changes only on drive-direction edges, and input is taken on sample-direction edges.
- R6: Mode bits 4:3 set the half-period of the serial clock: 1, 2 or 4 system clocks for the values 0, 1 and 2. The value 3 behaves as 2.
- R7: Index 5 bit 0 sets the idle level of the serial clock. While no transfer runs, the clock follows that bit one cycle later.
- R8: The select pin named in the control word is active while bit 12 is set, and it stays active after the transfer ends. A control write with bits 13:12 clear releases it. Mode bit 2 makes that select's pin active-high.
- R9: With mode bit 5 set, a started transfer produces no clock edge until the data input is high.
- R10: Index 4 bit 0 enables the clock generator. A start written while it is 0 is dropped and busy stays 0.
- R11: A control write while busy is ignored completely: no new transfer starts and the select pins do not change.
- R12: Register layout and readback:
  - index 2 holds the mode fields of selects 0 and 1 in bits 5:0 and 11:6,
  - index 3 holds selects 2 and 3 in the same positions,
  - all setup registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register word index |
| host_we | input | 1 | Write strobe for one clock |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the addressed register, combinational |
| mw_sclk | output | 1 | Serial clock |
| mw_sdo | output | 1 | Serial data to the target |
| mw_sdi | input | 1 | Serial data from the target, also the ready line |
| mw_cs | output | NUM_CS | Select pins, polarity set per select |

## Verification
The bench mixes random edge, polarity, divider and count settings with directed cases:
- zero transmit bits with a receive phase,
- zero receive bits,
- divider code 3,
- a start written while the clock generator is off,
- a start written in the middle of a running transfer,
- a ready wait.

A design that mixed up lead and trail edges would shift its transmit bits by one cell, or sample input half a cell early. The bench would then see wrong captured words.

A design that honoured a start while busy would emit extra edges or move the select. One that ignored the ready bit would clock before the input rose.

A wrong divider shows up as a wrong span between first and last edge. A select that dropped at the end of a transfer shows up in the pin check after busy falls.

// File: rtl/mw_pkg.sv
package mw_pkg;
   localparam int WORD_W = 16;
   localparam int CNT_W  = 5;
   localparam int MODE_W = 6;
   localparam int HC_W   = 2;

   typedef enum logic [2:0] {
      RA_DATA = 3'd0,
      RA_CTRL = 3'd1,
      RA_SET1 = 3'd2,
      RA_SET2 = 3'd3,
      RA_SET3 = 3'd4,
      RA_SET4 = 3'd5
   } reg_addr_e;

   typedef struct packed {
      logic       rdy_chk;
      logic [1:0] div;
      logic       cs_hi;
      logic       drv_rise;
      logic       smp_rise;
   } mode_t;
endpackage

// File: rtl/mw_regs.sv
module mw_regs
   import mw_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic              busy,
   input  logic              rx_flag,
   input  logic [WORD_W-1:0] rx_word,
   output logic [WORD_W-1:0] tx_word,
   output logic              clk_en,
   output logic              idle_inv,
   output logic              start,
   output logic [1:0]        xfer_sel,
   output logic [CNT_W-1:0]  tx_cnt,
   output logic [CNT_W-1:0]  rx_cnt,
   output logic              cs_act,
   output logic [1:0]        cs_sel,
   output mode_t             modes [4]
);
   localparam int PAIR_W = 2 * MODE_W;

   reg_addr_e          ra;
   logic               ctrl_wr;
   logic [12:0]        ctrl_q;
   logic [PAIR_W-1:0]  set1_q, set2_q;
   logic               set3_q, set4_q;

   assign ra      = reg_addr_e'(addr);
   assign ctrl_wr = we && (ra == RA_CTRL) && !busy;
   assign start   = ctrl_wr && wdata[13] && set3_q;
   assign xfer_sel = wdata[11:10];
   assign tx_cnt   = wdata[9:5];
   assign rx_cnt   = wdata[4:0];
   assign cs_act   = ctrl_q[12];
   assign cs_sel   = ctrl_q[11:10];
   assign clk_en   = set3_q;
   assign idle_inv = set4_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_word <= '0;
         ctrl_q  <= '0;
         set1_q  <= '0;
         set2_q  <= '0;
         set3_q  <= 1'b0;
         set4_q  <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= wdata[12:0];
         if (we) begin
            case (ra)
               RA_DATA: tx_word <= wdata;
               RA_SET1: set1_q  <= wdata[PAIR_W-1:0];
               RA_SET2: set2_q  <= wdata[PAIR_W-1:0];
               RA_SET3: set3_q  <= wdata[0];
               RA_SET4: set4_q  <= wdata[0];
               default: ;
            endcase
         end
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_mode
      if (g >= NUM_CS) begin : g_absent
         assign modes[g] = '0;
      end else if (g < 2) begin : g_lo
         assign modes[g] = mode_t'(set1_q[MODE_W*g +: MODE_W]);
      end else begin : g_hi
         assign modes[g] = mode_t'(set2_q[MODE_W*(g-2) +: MODE_W]);
      end
   end

   always_comb begin
      case (ra)
         RA_DATA: rdata = rx_word;
         RA_CTRL: rdata = {rx_flag, busy, 1'b0, ctrl_q};
         RA_SET1: rdata = {{(WORD_W-PAIR_W){1'b0}}, set1_q};
         RA_SET2: rdata = {{(WORD_W-PAIR_W){1'b0}}, set2_q};
         RA_SET3: rdata = {{(WORD_W-1){1'b0}}, set3_q};
         RA_SET4: rdata = {{(WORD_W-1){1'b0}}, set4_q};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/mw_shift.sv
module mw_shift
   import mw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mode_t             mode,
   input  logic              idle_inv,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [CNT_W-1:0]  tx_cnt,
   input  logic [CNT_W-1:0]  rx_cnt,
   input  logic              sdi,
   output logic              sclk,
   output logic              sdo,
   output logic              busy,
   output logic              rx_flag,
   output logic [WORD_W-1:0] rx_word
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

   logic [CNT_W-1:0]  txn, rxn, rxn_q, cells;
   logic [HC_W-1:0]   half_n, half_q, hcnt;
   logic              drv_lead_n, smp_lead_n, drv_lead, smp_lead;
   logic              idle_q, ph, in_rx, wait_rdy;
   logic [WORD_W-1:0] sh, rsh, rx_next;

   assign txn        = (tx_cnt > CNT_MAX) ? CNT_MAX : tx_cnt;
   assign rxn        = (rx_cnt > CNT_MAX) ? CNT_MAX : rx_cnt;
   assign drv_lead_n = (mode.drv_rise == !idle_inv);
   assign smp_lead_n = (mode.smp_rise == !idle_inv);
   assign rx_next    = {rsh[WORD_W-2:0], sdi};

   always_comb begin
      case (mode.div)
         2'd0:    half_n = HC_W'(0);
         2'd1:    half_n = HC_W'(1);
         default: half_n = HC_W'(3);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk <= 1'b0; sdo <= 1'b0; busy <= 1'b0; rx_flag <= 1'b0;
         rx_word <= '0; rxn_q <= '0; cells <= '0; half_q <= '0; hcnt <= '0;
         drv_lead <= 1'b0; smp_lead <= 1'b0; idle_q <= 1'b0; ph <= 1'b0;
         in_rx <= 1'b0; wait_rdy <= 1'b0; sh <= '0; rsh <= '0;
      end else if (start) begin
         rx_flag  <= 1'b0;
         rsh      <= '0;
         ph       <= 1'b0;
         hcnt     <= '0;
         half_q   <= half_n;
         drv_lead <= drv_lead_n;
         smp_lead <= smp_lead_n;
         idle_q   <= idle_inv;
         rxn_q    <= rxn;
         wait_rdy <= mode.rdy_chk;
         sclk     <= idle_inv;
         if (txn != '0) begin
            busy  <= 1'b1;
            in_rx <= 1'b0;
            cells <= txn;
            if (!drv_lead_n) begin
               sdo <= tx_word[WORD_W-1];
               sh  <= tx_word << 1;
            end else begin
               sh  <= tx_word;
            end
         end else if (rxn != '0) begin
            busy  <= 1'b1;
            in_rx <= 1'b1;
            cells <= rxn;
         end
      end else if (!busy) begin
         sclk <= idle_inv;
      end else if (wait_rdy) begin
         if (sdi) wait_rdy <= 1'b0;
      end else if (hcnt != half_q) begin
         hcnt <= hcnt + HC_W'(1);
      end else begin
         hcnt <= '0;
         if (!ph) begin
            ph   <= 1'b1;
            sclk <= !idle_q;
            if (!in_rx && drv_lead) begin
               sdo <= sh[WORD_W-1];
               sh  <= sh << 1;
            end
            if (in_rx && smp_lead) rsh <= rx_next;
         end else begin
            ph   <= 1'b0;
            sclk <= idle_q;
            if (in_rx && !smp_lead) rsh <= rx_next;
            if (cells == CNT_W'(1)) begin
               if (!in_rx && rxn_q != '0) begin
                  in_rx <= 1'b1;
                  cells <= rxn_q;
               end else begin
                  busy <= 1'b0;
                  if (in_rx) begin
                     rx_flag <= 1'b1;
                     rx_word <= smp_lead ? rsh : rx_next;
                  end
               end
            end else begin
               cells <= cells - CNT_W'(1);
               if (!in_rx && !drv_lead) begin
                  sdo <= sh[WORD_W-1];
                  sh  <= sh << 1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mw_csgen.sv
module mw_csgen #(
   parameter int NUM_CS = 4
) (
   input  logic              cs_act,
   input  logic [1:0]        cs_sel,
   input  logic [NUM_CS-1:0] cs_pol,
   output logic [NUM_CS-1:0] cs_pin
);
   for (genvar g = 0; g < NUM_CS; g++) begin : g_pin
      assign cs_pin[g] = ((cs_act && cs_sel == 2'(g)) == cs_pol[g]);
   end
endmodule

// File: rtl/mw_master.sv
module mw_master
   import mw_pkg::*;
#(
   parameter int NUM_CS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        host_addr,
   input  logic              host_we,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_rdata,
   output logic              mw_sclk,
   output logic              mw_sdo,
   input  logic              mw_sdi,
   output logic [NUM_CS-1:0] mw_cs
);
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("mw_master: NUM_CS must be 1 to 4");
   end

   logic              eng_busy, rx_flag, clk_en, idle_inv, start, cs_act;
   logic [WORD_W-1:0] rx_word, tx_word;
   logic [1:0]        xfer_sel, cs_sel;
   logic [CNT_W-1:0]  tx_cnt, rx_cnt;
   mode_t             modes [4];
   mode_t             xfer_mode;
   logic [NUM_CS-1:0] cs_pol;

   assign xfer_mode = modes[xfer_sel];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_pol
      assign cs_pol[g] = modes[g].cs_hi;
   end

   mw_regs #(.NUM_CS(NUM_CS)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(host_addr), .we(host_we),
      .wdata(host_wdata), .rdata(host_rdata), .busy(eng_busy),
      .rx_flag(rx_flag), .rx_word(rx_word), .tx_word(tx_word),
      .clk_en(clk_en), .idle_inv(idle_inv), .start(start),
      .xfer_sel(xfer_sel), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
      .cs_act(cs_act), .cs_sel(cs_sel), .modes(modes)
   );

   mw_shift u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(xfer_mode),
      .idle_inv(idle_inv), .tx_word(tx_word), .tx_cnt(tx_cnt),
      .rx_cnt(rx_cnt), .sdi(mw_sdi), .sclk(mw_sclk), .sdo(mw_sdo),
      .busy(eng_busy), .rx_flag(rx_flag), .rx_word(rx_word)
   );

   mw_csgen #(.NUM_CS(NUM_CS)) u_csgen (
      .cs_act(cs_act), .cs_sel(cs_sel), .cs_pol(cs_pol), .cs_pin(mw_cs)
   );
endmodule

// File: rtl/mw_master_chk.sv
module mw_master_chk #(
   parameter int NUM_CS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              clk_en,
   input logic              idle_inv,
   input logic              rx_flag,
   input logic              sclk,
   input logic              host_we,
   input logic [2:0]        host_addr,
   input logic [NUM_CS-1:0] mw_cs
);
   p_start_needs_clken_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> clk_en);

   p_flag_low_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rx_flag);

   p_flag_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $fell(busy));

   p_sclk_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (sclk == $past(idle_inv)));

   p_ctrl_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && host_addr == 3'd1) |=> $stable(mw_cs));
endmodule

bind mw_master mw_master_chk #(.NUM_CS(NUM_CS)) u_mw_chk (
   .clk(clk), .rst_n(rst_n), .busy(eng_busy), .clk_en(clk_en),
   .idle_inv(idle_inv), .rx_flag(rx_flag), .sclk(mw_sclk),
   .host_we(host_we), .host_addr(host_addr), .mw_cs(mw_cs)
);

// File: tb/mw_master_bench.sv
`timescale 1ns/1ps
module mw_master_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_we = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        sclk, sdo;
   logic        sdi = 1'b0;
   logic [3:0]  cs;

   int n_chk = 0, n_fail = 0;

   // shadow state kept by the bench
   logic [5:0]  mode_m [4];
   logic [11:0] set1_m = '0, set2_m = '0;

   // serial monitor state
   int          cyc = 0, edge_cnt = 0, rx_idx = 0, first_cyc = 0, last_cyc = 0;
   int          m_txn = 0, m_rxn = 0;
   bit          m_drv_rise = 0, m_smp_rise = 0;
   logic [15:0] m_rxval = '0, cap = '0;
   logic [3:0]  cs_seen = '0;
   logic        sclk_prev = 1'b0;

   // per-transfer context
   int          x_sel, x_txn, x_rxn;
   logic [5:0]  x_md;
   bit          x_idle;
   logic [15:0] x_tx, x_rx;

   mw_master #(.NUM_CS(4)) u_mw_master (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mw_sclk(sclk),
      .mw_sdo(sdo), .mw_sdi(sdi), .mw_cs(cs)
   );

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      if (sclk !== sclk_prev) begin
         if (edge_cnt == 0) begin
            first_cyc = cyc;
            cs_seen = cs;
         end
         last_cyc = cyc;
         if (edge_cnt < 2 * m_txn) begin
            if (sclk != m_drv_rise) cap = {cap[14:0], sdo};
         end else if (sclk == m_smp_rise) begin
            rx_idx++;
            if (rx_idx < m_rxn) sdi = m_rxval[m_rxn-1-rx_idx];
         end
         edge_cnt++;
      end
      sclk_prev = sclk;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   function automatic logic [3:0] exp_cs(input bit act, input int sel);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = ((act && i == sel) == mode_m[i][2]);
      return r;
   endfunction

   function automatic int half_of(input logic [5:0] md);
      return (md[4:3] == 2'd0) ? 1 : (md[4:3] == 2'd1) ? 2 : 4;
   endfunction

   task automatic wait_idle();
      logic [15:0] d;
      for (int i = 0; i < 3000; i++) begin
         rd(3'd1, d);
         if (!d[14]) break;
      end
   endtask

   task automatic start_xfer();
      logic [15:0] d;
      mode_m[x_sel] = x_md;
      if (x_sel < 2) begin
         set1_m[6*x_sel +: 6] = x_md;
         wr(3'd2, {4'b0, set1_m});
         rd(3'd2, d);
         check("R12 setup1 readback", d, {4'b0, set1_m});
      end else begin
         set2_m[6*(x_sel-2) +: 6] = x_md;
         wr(3'd3, {4'b0, set2_m});
         rd(3'd3, d);
         check("R12 setup2 readback", d, {4'b0, set2_m});
      end
      wr(3'd5, {15'b0, x_idle});
      wr(3'd0, x_tx);
      m_txn = x_txn; m_rxn = x_rxn; m_drv_rise = x_md[1]; m_smp_rise = x_md[0];
      m_rxval = x_rx; edge_cnt = 0; rx_idx = 0; cap = '0;
      if (x_rxn > 0) sdi = x_rx[x_rxn-1];
      wr(3'd1, 16'h3000 | 16'(x_sel << 10) | 16'(x_txn << 5) | 16'(x_rxn));
   endtask

   task automatic finish_xfer();
      logic [15:0] d;
      logic [31:0] exp_tx, exp_rx;
      int n;
      wait_idle();
      n = x_txn + x_rxn;
      exp_tx = {16'b0, x_tx} >> (16 - x_txn);
      exp_rx = (x_rxn == 0) ? 32'd0 : ({16'b0, x_rx} & ((32'd1 << x_rxn) - 1));
      check("R2 edge count", edge_cnt, 2 * n);
      check("R2/R5 transmitted bits", {16'b0, cap}, exp_tx);
      rd(3'd1, d);
      check("R3/R4 receive flag", {31'b0, d[15]}, {31'b0, x_rxn != 0});
      check("R4 busy clear", {31'b0, d[14]}, 32'd0);
      if (x_rxn != 0) begin
         rd(3'd0, d);
         check("R3/R5 received word", {16'b0, d}, exp_rx);
      end
      check("R6 edge span", last_cyc - first_cyc, (2 * n - 1) * half_of(x_md));
      check("R7 clock rests at idle", {31'b0, sclk}, {31'b0, x_idle});
      check("R8 select during transfer", {28'b0, cs_seen}, {28'b0, exp_cs(1, x_sel)});
      check("R8 select held after transfer", {28'b0, cs}, {28'b0, exp_cs(1, x_sel)});
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
   end

   initial begin
      logic [15:0] d;
      for (int i = 0; i < 4; i++) mode_m[i] = '0;
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd1, d); check("R1 control after reset", {16'b0, d}, 32'd0);
      rd(3'd0, d); check("R1 data after reset", {16'b0, d}, 32'd0);
      check("R1 select pins", {28'b0, cs}, 32'hF);
      check("R1 sclk low", {31'b0, sclk}, 32'd0);
      check("R1 sdo low", {31'b0, sdo}, 32'd0);

      wr(3'd4, 16'd1);
      rd(3'd4, d); check("R12 setup3 readback", {16'b0, d}, 32'd1);

      // directed: full transmit word, no receive (R2)
      x_sel = 0; x_md = 6'b000000; x_idle = 0; x_tx = 16'hA5C3; x_txn = 16; x_rxn = 0; x_rx = 0;
      start_xfer();
      rd(3'd1, d);
      check("R4 busy during transfer", {31'b0, d[14]}, 32'd1);
      finish_xfer();

      // directed: divider code 3, active-high select, idle high
      x_sel = 3; x_md = 6'b011111; x_idle = 1; x_tx = 16'h3C00; x_txn = 8; x_rxn = 12; x_rx = 16'h0ABC;
      start_xfer(); finish_xfer();

      // directed: receive only (R3)
      x_sel = 2; x_md = 6'b001010; x_idle = 0; x_tx = 16'hFFFF; x_txn = 0; x_rxn = 5; x_rx = 16'h0013;
      start_xfer(); finish_xfer();

      // random mix (R2 R3 R5 R6 R7 R8)
      for (int k = 0; k < 40; k++) begin
         x_sel = $urandom_range(0, 3);
         x_md = 6'($urandom_range(0, 31));
         x_idle = 1'($urandom_range(0, 1));
         x_tx = 16'($urandom);
         x_rx = 16'($urandom);
         x_txn = $urandom_range(0, 16);
         x_rxn = $urandom_range(0, 16);
         if (x_txn + x_rxn == 0) x_txn = 1;
         start_xfer(); finish_xfer();
      end

      // R8 release
      wr(3'd1, {4'b0, 2'(x_sel), 10'b0});
      check("R8 select released", {28'b0, cs}, {28'b0, exp_cs(0, 0)});

      // R10 start while clock generator is off
      wr(3'd4, 16'd0);
      edge_cnt = 0;
      wr(3'd1, 16'h3000 | 16'(1 << 10) | 16'(4 << 5));
      repeat (10) @(negedge clk);
      rd(3'd1, d);
      check("R10 no busy when disabled", {31'b0, d[14]}, 32'd0);
      check("R10 no clock edges when disabled", edge_cnt, 32'd0);
      wr(3'd4, 16'd1);

      // R11 control write during a transfer
      x_sel = 1; x_md = 6'b010000; x_idle = 0; x_tx = 16'h9F61; x_txn = 16; x_rxn = 0; x_rx = 0;
      start_xfer();
      repeat (10) @(negedge clk);
      wr(3'd1, 16'h3000 | 16'(2 << 10) | 16'(3 << 5));
      check("R11 select unchanged", {28'b0, cs}, {28'b0, exp_cs(1, 1)});
      finish_xfer();

      // R9 ready wait
      x_sel = 0; x_md = 6'b100000; x_idle = 0; x_tx = 16'hC000; x_txn = 2; x_rxn = 0; x_rx = 0;
      sdi = 1'b0;
      start_xfer();
      repeat (20) @(negedge clk);
      rd(3'd1, d);
      check("R9 busy while waiting", {31'b0, d[14]}, 32'd1);
      check("R9 no edges before ready", edge_cnt, 32'd0);
      sdi = 1'b1;
      finish_xfer();

      summary();
   end
endmodule